// File: doc/BRIEF.md
# Power-Good Strap Latch and Decoder

This block captures a set of board configuration straps at the moment a shared pad, driven low by the platform when the processor supply is good, is first seen low. The captured word is held for the rest of operation and decoded into a CPU clock frequency code, a flag for undefined frequency codes, and several mode flags: whether the shared differential pair carries a second CPU clock or a serial reference clock, whether the spread output runs at 100 or 96 MHz, whether two dual-use pads act as clock-request inputs, whether test mode is active and, in test mode, whether the test outputs drive a divided reference or float.

Once the capture has happened, the same pad takes a new role: its level becomes a live, active-high power-down request. Capture is one-shot. Further strap or pad activity is ignored, with one exception. When test mode was captured, a high-then-low sequence on the pad captures the straps again. The pad is passed through a parameterised synchronizer before the control state machine sees it. Test mode is taken from `test_lvl_strap`, the output of an external high-threshold comparator on the FS_C pad. The analog threshold itself is outside this block.

The control state machine has five states:
- WAIT: after reset, waiting for the pad to read low.
- GRAB: the single cycle that follows a capture.
- HOLD: locked in normal mode.
- TEST_LOW: test mode, with the pad low.
- TEST_HIGH: test mode, with the pad high and armed for a recapture.

Its transitions are:
- WAIT to GRAB when the synchronized pad is low. The capture occurs on this edge.
- GRAB to TEST_LOW if the captured word has test mode set, otherwise GRAB to HOLD.
- HOLD stays in HOLD.
- TEST_LOW to TEST_HIGH when the pad is high.
- TEST_HIGH to GRAB when the pad is low. The recapture occurs on this edge.

Top module: `pgood_strap_top`

## Requirements
- R1: While reset is active and after its release, before any capture, the outputs read as follows. `cpu_freq` is 0 (the 100 MHz code). `freq_bad`, `pair_is_cpu`, `ssc_is_100`, `req_pins_mode`, `test_mode`, `test_ref_div`, `power_down` and `locked` are all 0.
- R2: The pad is synchronized through SYNC_STAGES flops, reset to the high (not-good) level. With the default of 2, a pad driven low just before edge E0 causes the straps to be captured on edge E2.
- R3: The frequency straps are written as {fs_c, fs_b, fs_a} and give `cpu_freq` as follows: 101 gives 0 (100 MHz), 001 gives 1 (66.6667 MHz), 011 gives 2 (83.3333 MHz) and 010 gives 3 (71.4286 MHz).
- R4: The frequency codes 000, 100, 110 and 111 are undefined. Each gives `cpu_freq` = 0 and `freq_bad` = 1. The four defined codes give `freq_bad` = 0.
- R5: In normal mode, once the straps are captured, later strap changes and later pad transitions leave every decoded output unchanged until reset.
- R6: `locked` rises on the clock edge after the capture edge and stays at 1 until reset.
- R7: `power_down` is 0 while `locked` is 0. While `locked` is 1, `power_down` equals the synchronized pad level, and a high pad requests power-down.
- R8: `test_mode` is the captured `test_lvl_strap`. While `test_mode` is 1, a high-then-low sequence on the pad recaptures all straps. Recapturing with `test_lvl_strap` at 0 returns the block to one-shot normal mode.
- R9: `test_ref_div` equals the captured fs_b when `test_mode` is 1, and is 0 otherwise.
- R10: The captured strap values appear directly on three outputs: `itp_strap` on `pair_is_cpu` (1 means CPU clock on the shared pair), `ssc_sel_strap` on `ssc_is_100` (1 means 100 MHz) and `req_sel_strap` on `req_pins_mode` (1 means the pads act as request inputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Global active-low reset |
| pg_pd_pin | input | 1 | Power-good (active low) before capture, power-down (active high) after |
| freq_strap | input | 3 | Frequency straps {fs_c, fs_b, fs_a} |
| itp_strap | input | 1 | Shared pair select strap |
| ssc_sel_strap | input | 1 | Spread output frequency strap |
| req_sel_strap | input | 1 | Request-pin role strap |
| test_lvl_strap | input | 1 | High-threshold comparator result on fs_c |
| cpu_freq | output | 2 | Decoded CPU frequency code |
| freq_bad | output | 1 | Captured frequency code is undefined |
| pair_is_cpu | output | 1 | Shared pair carries the CPU clock |
| ssc_is_100 | output | 1 | Spread output at 100 MHz |
| req_pins_mode | output | 1 | Dual-use pads act as request inputs |
| test_mode | output | 1 | Test mode captured |
| test_ref_div | output | 1 | Test outputs drive divided reference |
| power_down | output | 1 | Live power-down request |
| locked | output | 1 | Capture has taken place |

## Verification
The bench sweeps all eight frequency codes with varied mode straps. A wrong decode table, or an undefined code that is not defaulted, shows up as a mismatched `cpu_freq` or `freq_bad`. After a normal lock, the bench changes the straps and toggles the pad. A latch that is not one-shot would take the new values, and a pad not turned into power-down would leave `power_down` at 0. In test mode, a recapture must take fresh straps and then drop back to one-shot. A design that never recaptured, or that stayed in test mode, would keep stale codes or keep accepting them. The bench checks the exact edge on which `locked` rises, and that `power_down` is held at 0 before the lock even when the pad is high.

// File: rtl/pgood_strap_pkg.sv
package pgood_strap_pkg;

    typedef enum logic [1:0] {
        FREQ_100 = 2'd0,
        FREQ_66  = 2'd1,
        FREQ_83  = 2'd2,
        FREQ_71  = 2'd3
    } cpu_freq_e;

    typedef enum logic [2:0] {
        ST_WAIT      = 3'd0,
        ST_GRAB      = 3'd1,
        ST_HOLD      = 3'd2,
        ST_TEST_LOW  = 3'd3,
        ST_TEST_HIGH = 3'd4
    } ctl_state_e;

    localparam int FS_W = 3;

    typedef struct packed {
        logic [FS_W-1:0] fs;   // {c, b, a}
        logic            itp;
        logic            ssc;
        logic            req;
        logic            tlvl;
    } strap_word_t;

    localparam strap_word_t STRAP_RESET = '{fs: 3'b101, itp: 1'b0, ssc: 1'b0,
                                            req: 1'b0, tlvl: 1'b0};

    function automatic cpu_freq_e fs_to_freq(input logic [FS_W-1:0] fs);
        unique case (fs)
            3'b001:  return FREQ_66;
            3'b011:  return FREQ_83;
            3'b010:  return FREQ_71;
            default: return FREQ_100;
        endcase
    endfunction

    function automatic logic fs_undefined(input logic [FS_W-1:0] fs);
        return !(fs == 3'b101 || fs == 3'b001 || fs == 3'b011 || fs == 3'b010);
    endfunction

endpackage

// File: rtl/pgood_sync.sv
module pgood_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/pgood_ctl_fsm.sv
module pgood_ctl_fsm
    import pgood_strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic test_latched,
    output logic cap_en,
    output logic locked
);
    ctl_state_e state_q, state_d;
    logic       locked_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:      if (!pin_s) state_d = ST_GRAB;
            ST_GRAB:      state_d = test_latched ? ST_TEST_LOW : ST_HOLD;
            ST_HOLD:      state_d = ST_HOLD;
            ST_TEST_LOW:  if (pin_s) state_d = ST_TEST_HIGH;
            ST_TEST_HIGH: if (!pin_s) state_d = ST_GRAB;
            default:      state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   locked_q <= 1'b0;
        else if (state_q == ST_GRAB)  locked_q <= 1'b1;
    end

    always_comb begin
        cap_en = 1'b0;
        unique case (state_q)
            ST_WAIT, ST_TEST_HIGH: cap_en = !pin_s;
            default:               cap_en = 1'b0;
        endcase
        locked = locked_q;
    end
endmodule

// File: rtl/pgood_strap_reg.sv
module pgood_strap_reg
    import pgood_strap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  strap_word_t raw,
    output logic [1:0]  cpu_freq,
    output logic        freq_bad,
    output logic        pair_is_cpu,
    output logic        ssc_is_100,
    output logic        req_pins_mode,
    output logic        test_mode,
    output logic        test_ref_div
);
    strap_word_t held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= STRAP_RESET;
        else if (cap_en) held_q <= raw;
    end

    always_comb begin
        cpu_freq      = fs_to_freq(held_q.fs);
        freq_bad      = fs_undefined(held_q.fs);
        pair_is_cpu   = held_q.itp;
        ssc_is_100    = held_q.ssc;
        req_pins_mode = held_q.req;
        test_mode     = held_q.tlvl;
        test_ref_div  = held_q.tlvl & held_q.fs[1];
    end
endmodule

// File: rtl/pgood_strap_top.sv
module pgood_strap_top
    import pgood_strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_pd_pin,
    input  logic [2:0] freq_strap,
    input  logic       itp_strap,
    input  logic       ssc_sel_strap,
    input  logic       req_sel_strap,
    input  logic       test_lvl_strap,
    output logic [1:0] cpu_freq,
    output logic       freq_bad,
    output logic       pair_is_cpu,
    output logic       ssc_is_100,
    output logic       req_pins_mode,
    output logic       test_mode,
    output logic       test_ref_div,
    output logic       power_down,
    output logic       locked
);
    logic        pin_s;
    logic        cap_en;
    strap_word_t raw;

    assign raw = '{fs: freq_strap, itp: itp_strap, ssc: ssc_sel_strap,
                   req: req_sel_strap, tlvl: test_lvl_strap};

    pgood_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pg_pd_pin),
        .q_out (pin_s)
    );

    pgood_ctl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_s        (pin_s),
        .test_latched (test_mode),
        .cap_en       (cap_en),
        .locked       (locked)
    );

    pgood_strap_reg u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (cap_en),
        .raw           (raw),
        .cpu_freq      (cpu_freq),
        .freq_bad      (freq_bad),
        .pair_is_cpu   (pair_is_cpu),
        .ssc_is_100    (ssc_is_100),
        .req_pins_mode (req_pins_mode),
        .test_mode     (test_mode),
        .test_ref_div  (test_ref_div)
    );

    assign power_down = locked & pin_s;
endmodule

// File: rtl/pgood_strap_chk.sv
module pgood_strap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cpu_freq,
    input logic       freq_bad,
    input logic       pair_is_cpu,
    input logic       ssc_is_100,
    input logic       req_pins_mode,
    input logic       test_mode,
    input logic       test_ref_div,
    input logic       power_down,
    input logic       locked
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);                                              // R6

    AST_ONE_SHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !test_mode) |=> ($stable(cpu_freq) && $stable(freq_bad) &&
        $stable(pair_is_cpu) && $stable(ssc_is_100) &&
        $stable(req_pins_mode) && $stable(test_mode)));                  // R5

    AST_PD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !power_down);                                        // R7

    AST_BAD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        freq_bad |-> (cpu_freq == 2'd0));                                // R4

    AST_REFDIV_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        test_ref_div |-> test_mode);                                     // R9
endmodule

bind pgood_strap_top pgood_strap_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_freq      (cpu_freq),
    .freq_bad      (freq_bad),
    .pair_is_cpu   (pair_is_cpu),
    .ssc_is_100    (ssc_is_100),
    .req_pins_mode (req_pins_mode),
    .test_mode     (test_mode),
    .test_ref_div  (test_ref_div),
    .power_down    (power_down),
    .locked        (locked)
);

// File: tb/sim_pgood_strap_top.sv
module sim_pgood_strap_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg_pd_pin = 1'b1;
    logic [2:0] freq_strap = 3'b000;
    logic       itp_strap = 1'b0, ssc_sel_strap = 1'b0;
    logic       req_sel_strap = 1'b0, test_lvl_strap = 1'b0;
    logic [1:0] cpu_freq;
    logic       freq_bad, pair_is_cpu, ssc_is_100, req_pins_mode;
    logic       test_mode, test_ref_div, power_down, locked;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pgood_strap_top u0 (
        .clk(clk), .rst_n(rst_n), .pg_pd_pin(pg_pd_pin), .freq_strap(freq_strap),
        .itp_strap(itp_strap), .ssc_sel_strap(ssc_sel_strap),
        .req_sel_strap(req_sel_strap), .test_lvl_strap(test_lvl_strap),
        .cpu_freq(cpu_freq), .freq_bad(freq_bad), .pair_is_cpu(pair_is_cpu),
        .ssc_is_100(ssc_is_100), .req_pins_mode(req_pins_mode),
        .test_mode(test_mode), .test_ref_div(test_ref_div),
        .power_down(power_down), .locked(locked)
    );

    // vector: [15:13] fs, 12 itp, 11 ssc, 10 req, 9 tlvl,
    //         [8:7] exp freq, 6 exp bad, 5 exp test, 4 exp refdiv
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {3'b101, 4'b1000, 2'd0, 3'b000, 4'h0},
        {3'b001, 4'b0100, 2'd1, 3'b000, 4'h0},
        {3'b011, 4'b0010, 2'd2, 3'b000, 4'h0},
        {3'b010, 4'b1110, 2'd3, 3'b000, 4'h0},
        {3'b000, 4'b0000, 2'd0, 3'b100, 4'h0},
        {3'b100, 4'b1010, 2'd0, 3'b100, 4'h0},
        {3'b110, 4'b0100, 2'd0, 3'b100, 4'h0},
        {3'b111, 4'b0010, 2'd0, 3'b100, 4'h0},
        {3'b110, 4'b0001, 2'd0, 3'b111, 4'h0},
        {3'b101, 4'b0001, 2'd0, 3'b010, 4'h0}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pg_pd_pin = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic set_straps(input logic [2:0] fs, input logic [3:0] m);
        freq_strap = fs;
        {itp_strap, ssc_sel_strap, req_sel_strap, test_lvl_strap} = m;
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, cpu_freq, freq_bad, pair_is_cpu, ssc_is_100, req_pins_mode, test_mode};
    endfunction

    initial begin
        logic [7:0] snap;
        // R1: reset state
        rst_n = 1'b0;
        tick(1);
        chk("R1 in reset", {cpu_freq, freq_bad, pair_is_cpu, ssc_is_100, req_pins_mode,
            test_mode, test_ref_div}, 8'h00);
        chk("R1 pd/lock in reset", {6'd0, power_down, locked}, 8'h00);
        rst_n = 1'b1;
        tick(3);
        chk("R1 after release", {cpu_freq, freq_bad, test_mode, test_ref_div, power_down,
            locked, 1'b0}, 8'h00);
        // R7: pad high before lock gives no power-down
        chk("R7 no pd before lock", {7'd0, power_down}, 8'h00);

        // Vector sweep: R3 R4 R9 R10 R2 R6
        for (int i = 0; i < NV; i++) begin
            do_reset();
            set_straps(VEC[i][15:13], VEC[i][12:9]);
            pg_pd_pin = 1'b0;
            tick(3);
            chk("R3/R4 freq", {6'd0, cpu_freq}, {6'd0, VEC[i][8:7]});
            chk("R4 bad flag", {7'd0, freq_bad}, {7'd0, VEC[i][6]});
            chk("R10 mode flags", {5'd0, pair_is_cpu, ssc_is_100, req_pins_mode},
                {5'd0, VEC[i][12:10]});
            chk("R8 test flag", {7'd0, test_mode}, {7'd0, VEC[i][5]});
            chk("R9 ref div", {7'd0, test_ref_div}, {7'd0, VEC[i][5] & VEC[i][14]});
            chk("R6 R2 not yet locked", {7'd0, locked}, 8'h00);
            tick(1);
            chk("R6 locked next edge", {7'd0, locked}, 8'h01);
        end

        // R2: capture edge exactly SYNC_STAGES after the pad falls
        do_reset();
        set_straps(3'b011, 4'b0000);
        pg_pd_pin = 1'b0;
        tick(2);
        chk("R2 not captured early", outs(), {1'b0, 2'd0, 1'b0, 4'h0});
        tick(1);
        chk("R2 captured on edge 2", outs(), {1'b0, 2'd2, 1'b0, 4'h0});

        // R5 R7: one-shot in normal mode; pad becomes power-down
        do_reset();
        set_straps(3'b001, 4'b1010);
        pg_pd_pin = 1'b0;
        tick(4);
        snap = outs();
        set_straps(3'b010, 4'b0101);
        pg_pd_pin = 1'b1;
        tick(4);
        chk("R7 pd follows pad high", {7'd0, power_down}, 8'h01);
        chk("R5 held while pad high", outs(), snap);
        pg_pd_pin = 1'b0;
        tick(4);
        chk("R7 pd follows pad low", {7'd0, power_down}, 8'h00);
        chk("R5 no recapture", outs(), snap);
        chk("R6 still locked", {7'd0, locked}, 8'h01);

        // R8 R9: test-mode recapture, then return to one-shot
        do_reset();
        set_straps(3'b110, 4'b0001);
        pg_pd_pin = 1'b0;
        tick(4);
        chk("R9 refdiv in test", {7'd0, test_ref_div}, 8'h01);
        set_straps(3'b001, 4'b1001);
        pg_pd_pin = 1'b1;
        tick(4);
        chk("R7 pd in test mode", {7'd0, power_down}, 8'h01);
        pg_pd_pin = 1'b0;
        tick(4);
        chk("R8 recapture", outs(), {1'b0, 2'd1, 1'b0, 1'b1, 2'b00, 1'b1});
        chk("R9 refdiv follows fs_b", {7'd0, test_ref_div}, 8'h00);
        set_straps(3'b011, 4'b0000);
        pg_pd_pin = 1'b1;
        tick(4);
        pg_pd_pin = 1'b0;
        tick(4);
        chk("R8 leave test", outs(), {1'b0, 2'd2, 1'b0, 4'h0});
        set_straps(3'b010, 4'b1111);
        pg_pd_pin = 1'b1;
        tick(4);
        pg_pd_pin = 1'b0;
        tick(4);
        chk("R8 R5 one-shot again", outs(), {1'b0, 2'd2, 1'b0, 4'h0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule